// File: doc/BRIEF.md
# Shared-Rail Performance-State Sequencer

This block picks one operating point for a group of cores that share a clock and a supply rail, and moves the rail and the clock to that point in an order that keeps the logic safe at every instant. Each core presents a requested performance index and an active bit. Index 0 is the fastest point, and the largest index is the slowest. The block selects the fastest request among the active cores. It then looks up a supply code that depends on both the chosen index and the number of active cores.

When the clock is to speed up, the supply is raised first, one code unit at a time. The clock generator is told to relock only after the rail has reached its new value. When the clock is to slow down, the clock generator relocks first, and the rail is lowered after lock returns. Each supply step goes out as a one-cycle command to an external regulator. The block waits for the regulator's acknowledge and then for a minimum pacing interval before the next step. A request that changes while a move is under way is not lost. It is taken up once the move in progress has finished.

Top module: `dvfs_pstate_seq`

## Requirements
- R1: After reset, freq_code is FBASE+(NPS-1)*0 for index NPS-1 (i.e. the slowest point), volt_code is the supply code of index NPS-1 with one active core, and busy, vr_cmd and pll_relock are low.
- R2: The selected index is the smallest core_req field (core i occupies bits [i*PSW +: PSW]) among cores whose core_active bit is set. Requests of inactive cores have no effect.
- R3: At the end of a move, volt_code equals VBASE + (NPS-1-p)*VSTEP_PS + (n-1)*VSTEP_CNT, where p is the selected index and n the number of active cores.
- R4: At the end of a move, freq_code equals FBASE + (NPS-1-p)*FSTEP.
- R5: When the selected index is below the current one (faster), every supply command of the move comes before the single pll_relock pulse.
- R6: When the selected index is above the current one (slower), the single pll_relock pulse comes before every supply command of the move. When only the active count changes, only supply commands are issued.
- R7: Each vr_cmd pulse moves volt_code by exactly one unit, and volt_code never changes without a vr_cmd pulse.
- R8: Successive vr_cmd pulses are at least STEP_GAP cycles apart, and a vr_ack arrives between any two of them.
- R9: After a pll_relock pulse, the move does not complete (busy stays high) while pll_locked is low.
- R10: A request that changes during a move is held. The move in progress finishes at its original target, and the new target is applied afterwards.
- R11: While no core is active, no move starts and the outputs keep their values.
- R12: If the arbitrated index and active count equal the current ones, no move starts and busy stays low.
- R13: busy is high throughout every move, and vr_cmd and pll_relock are asserted only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | NCORE*PSW | Requested performance index per core, core i in bits [i*PSW +: PSW] |
| core_active | input | NCORE | Active bit per core |
| pll_locked | input | 1 | Clock generator lock indication |
| vr_ack | input | 1 | Regulator acknowledge of the last supply command |
| freq_code | output | FW | Target clock frequency code |
| volt_code | output | VW | Supply code currently commanded |
| vr_cmd | output | 1 | One-cycle strobe: volt_code holds a new step for the regulator |
| pll_relock | output | 1 | One-cycle strobe: relock to freq_code |
| busy | output | 1 | A move is in progress |

## Verification
The hardest case to reach is a request that changes in the middle of a long supply ramp. The bench gets there by starting the widest upward move, from the slowest point with one core to the fastest point with all cores. A few steps into that ramp it switches to a third target. It then checks that the first move lands exactly on its original codes and that busy falls for one cycle before the held target is taken up. Every ordered pair of indices is also swept, with the winning core and the active mask rotated and the inactive cores asking for index 0. This proves that inactive requests never win and that both orderings occur over all ramp lengths.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOOK,
    SQ_SEL,
    SQ_RAMP_UP,
    SQ_LOCK_UP,
    SQ_LOCK_DN,
    SQ_RAMP_DN,
    SQ_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    RP_IDLE,
    RP_STEP,
    RP_ACK,
    RP_GAP
  } ramp_state_t;

  function automatic int unsigned volt_of(input int unsigned ps, input int unsigned cnt,
                                          input int unsigned nps, input int unsigned vbase,
                                          input int unsigned vps, input int unsigned vcnt);
    return vbase + (nps - 1 - ps) * vps + (cnt - 1) * vcnt;
  endfunction

  function automatic int unsigned freq_of(input int unsigned ps, input int unsigned nps,
                                          input int unsigned fbase, input int unsigned fstep);
    return fbase + (nps - 1 - ps) * fstep;
  endfunction

endpackage

// File: rtl/dvfs_arbiter.sv
module dvfs_arbiter #(
  parameter int NCORE = 4,
  parameter int NPS   = 8,
  localparam int PSW = (NPS > 1) ? $clog2(NPS) : 1,
  localparam int CW  = $clog2(NCORE + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCORE*PSW-1:0] core_req,
  input  logic [NCORE-1:0]     core_active,
  output logic [PSW-1:0]       win_ps,
  output logic [CW-1:0]        win_cnt,
  output logic                 win_any
);

  localparam logic [PSW-1:0] SLOWEST = PSW'(NPS - 1);

  logic [PSW-1:0] best_c;
  logic [CW-1:0]  cnt_c;
  logic           any_c;

  always_comb begin
    best_c = SLOWEST;
    cnt_c  = '0;
    any_c  = 1'b0;
    for (int i = 0; i < NCORE; i++) begin
      logic [PSW-1:0] r;
      r = core_req[i*PSW +: PSW];
      if (r > SLOWEST) r = SLOWEST;
      if (core_active[i]) begin
        cnt_c = cnt_c + CW'(1);
        if (!any_c || (r < best_c)) best_c = r;
        any_c = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_ps  <= SLOWEST;
      win_cnt <= CW'(1);
      win_any <= 1'b0;
    end else begin
      win_ps  <= best_c;
      win_cnt <= cnt_c;
      win_any <= any_c;
    end
  end

endmodule

// File: rtl/dvfs_vlut.sv
module dvfs_vlut #(
  parameter int NCORE    = 4,
  parameter int NPS      = 8,
  parameter int VW       = 8,
  parameter int VBASE    = 40,
  parameter int VSTEP_PS = 3,
  parameter int VSTEP_CNT = 1,
  localparam int PSW = (NPS > 1) ? $clog2(NPS) : 1,
  localparam int CW  = $clog2(NCORE + 1),
  localparam int DEPTH = NPS * NCORE
) (
  input  logic           clk,
  input  logic [PSW-1:0] ps,
  input  logic [CW-1:0]  cnt,
  output logic [VW-1:0]  vcode
);
  import dvfs_pkg::*;

  logic [VW-1:0] rom [DEPTH];

  for (genvar p = 0; p < NPS; p++) begin : g_ps
    for (genvar c = 0; c < NCORE; c++) begin : g_cnt
      assign rom[p*NCORE + c] = VW'(volt_of(p, c + 1, NPS, VBASE, VSTEP_PS, VSTEP_CNT));
    end
  end

  logic [$clog2(DEPTH)-1:0] addr;
  always_comb begin
    int unsigned a;
    a = int'(ps) * NCORE + ((cnt == '0) ? 0 : int'(cnt) - 1);
    if (a >= DEPTH) a = DEPTH - 1;
    addr = a[$clog2(DEPTH)-1:0];
  end

  always_ff @(posedge clk) begin
    vcode <= rom[addr];
  end

endmodule

// File: rtl/dvfs_ramp.sv
module dvfs_ramp #(
  parameter int VW       = 8,
  parameter int STEP_GAP = 4,
  parameter int VRESET   = 40,
  localparam int GW = $clog2(STEP_GAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [VW-1:0] target,
  input  logic          vr_ack,
  output logic [VW-1:0] vcode,
  output logic          cmd,
  output logic          done
);
  import dvfs_pkg::*;

  ramp_state_t   st;
  logic [GW-1:0] gcnt;
  logic [VW-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RP_IDLE;
      vcode <= VW'(VRESET);
      tgt_q <= VW'(VRESET);
      gcnt  <= '0;
      cmd   <= 1'b0;
      done  <= 1'b0;
    end else begin
      cmd  <= 1'b0;
      done <= 1'b0;
      unique case (st)
        RP_IDLE: begin
          if (start) begin
            tgt_q <= target;
            if (target == vcode) done <= 1'b1;
            else st <= RP_STEP;
          end
        end
        RP_STEP: begin
          vcode <= (tgt_q > vcode) ? vcode + VW'(1) : vcode - VW'(1);
          cmd   <= 1'b1;
          st    <= RP_ACK;
        end
        RP_ACK: begin
          if (vr_ack) begin
            gcnt <= '0;
            st   <= RP_GAP;
          end
        end
        RP_GAP: begin
          gcnt <= gcnt + GW'(1);
          if (gcnt >= GW'(STEP_GAP - 1)) begin
            if (vcode == tgt_q) begin
              done <= 1'b1;
              st   <= RP_IDLE;
            end else begin
              st <= RP_STEP;
            end
          end
        end
        default: st <= RP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dvfs_pstate_seq.sv
module dvfs_pstate_seq #(
  parameter int NCORE     = 4,
  parameter int NPS       = 8,
  parameter int VW        = 8,
  parameter int FW        = 8,
  parameter int VBASE     = 40,
  parameter int VSTEP_PS  = 3,
  parameter int VSTEP_CNT = 1,
  parameter int FBASE     = 8,
  parameter int FSTEP     = 4,
  parameter int STEP_GAP  = 4,
  parameter int LOCK_HOLD = 2,
  localparam int PSW = (NPS > 1) ? $clog2(NPS) : 1,
  localparam int CW  = $clog2(NCORE + 1),
  localparam int LW  = $clog2(LOCK_HOLD + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCORE*PSW-1:0] core_req,
  input  logic [NCORE-1:0]     core_active,
  input  logic                 pll_locked,
  input  logic                 vr_ack,
  output logic [FW-1:0]        freq_code,
  output logic [VW-1:0]        volt_code,
  output logic                 vr_cmd,
  output logic                 pll_relock,
  output logic                 busy
);
  import dvfs_pkg::*;

  localparam int VRESET = volt_of(NPS - 1, 1, NPS, VBASE, VSTEP_PS, VSTEP_CNT);
  localparam int FRESET = freq_of(NPS - 1, NPS, FBASE, FSTEP);

  logic [PSW-1:0] win_ps;
  logic [CW-1:0]  win_cnt;
  logic           win_any;

  dvfs_arbiter #(.NCORE(NCORE), .NPS(NPS)) u_arb (
    .clk(clk), .rst(rst), .core_req(core_req), .core_active(core_active),
    .win_ps(win_ps), .win_cnt(win_cnt), .win_any(win_any)
  );

  logic [PSW-1:0] cur_ps, new_ps;
  logic [CW-1:0]  cur_cnt, new_cnt;
  logic [VW-1:0]  lut_v, vtgt;

  dvfs_vlut #(.NCORE(NCORE), .NPS(NPS), .VW(VW), .VBASE(VBASE),
              .VSTEP_PS(VSTEP_PS), .VSTEP_CNT(VSTEP_CNT)) u_lut (
    .clk(clk), .ps(new_ps), .cnt(new_cnt), .vcode(lut_v)
  );

  logic ramp_start, ramp_done;

  dvfs_ramp #(.VW(VW), .STEP_GAP(STEP_GAP), .VRESET(VRESET)) u_ramp (
    .clk(clk), .rst(rst), .start(ramp_start), .target(vtgt), .vr_ack(vr_ack),
    .vcode(volt_code), .cmd(vr_cmd), .done(ramp_done)
  );

  function automatic logic [FW-1:0] fcode(input logic [PSW-1:0] p);
    return FW'(FBASE + (NPS - 1 - int'(p)) * FSTEP);
  endfunction

  seq_state_t    st;
  logic [LW-1:0] hold;
  logic          lock_ok;

  assign lock_ok = (hold >= LW'(LOCK_HOLD)) && pll_locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      cur_ps     <= PSW'(NPS - 1);
      cur_cnt    <= CW'(1);
      new_ps     <= PSW'(NPS - 1);
      new_cnt    <= CW'(1);
      vtgt       <= VW'(VRESET);
      freq_code  <= FW'(FRESET);
      pll_relock <= 1'b0;
      ramp_start <= 1'b0;
      busy       <= 1'b0;
      hold       <= '0;
    end else begin
      pll_relock <= 1'b0;
      ramp_start <= 1'b0;
      if (hold < LW'(LOCK_HOLD)) hold <= hold + LW'(1);
      unique case (st)
        SQ_IDLE: begin
          if (win_any && ((win_ps != cur_ps) || (win_cnt != cur_cnt))) begin
            new_ps  <= win_ps;
            new_cnt <= win_cnt;
            busy    <= 1'b1;
            st      <= SQ_LOOK;
          end
        end
        SQ_LOOK: begin
          st <= SQ_SEL;
        end
        SQ_SEL: begin
          vtgt <= lut_v;
          if (new_ps > cur_ps) begin
            freq_code  <= fcode(new_ps);
            pll_relock <= 1'b1;
            hold       <= '0;
            st         <= SQ_LOCK_DN;
          end else begin
            ramp_start <= 1'b1;
            st         <= (new_ps < cur_ps) ? SQ_RAMP_UP : SQ_RAMP_DN;
          end
        end
        SQ_RAMP_UP: begin
          if (ramp_done) begin
            freq_code  <= fcode(new_ps);
            pll_relock <= 1'b1;
            hold       <= '0;
            st         <= SQ_LOCK_UP;
          end
        end
        SQ_LOCK_UP: begin
          if (lock_ok) st <= SQ_FIN;
        end
        SQ_LOCK_DN: begin
          if (lock_ok) begin
            ramp_start <= 1'b1;
            st         <= SQ_RAMP_DN;
          end
        end
        SQ_RAMP_DN: begin
          if (ramp_done) st <= SQ_FIN;
        end
        SQ_FIN: begin
          cur_ps  <= new_ps;
          cur_cnt <= new_cnt;
          busy    <= 1'b0;
          st      <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dvfs_pstate_seq_chk.sv
module dvfs_pstate_seq_chk #(
  parameter int VW = 8,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [FW-1:0] freq_code,
  input logic [VW-1:0] volt_code,
  input logic          vr_cmd,
  input logic          pll_relock,
  input logic          busy
);

  // R7
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    vr_cmd |-> ((volt_code == $past(volt_code) + VW'(1)) ||
                (volt_code == $past(volt_code) - VW'(1))));

  // R7
  volt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vr_cmd |-> $stable(volt_code));

  // R5
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_relock |-> $stable(freq_code));

  // R13
  relock_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pll_relock |-> busy);

  // R13
  cmd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    vr_cmd |-> busy);

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(vr_cmd && pll_relock));

  // R8
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    vr_cmd |=> !vr_cmd);

endmodule

bind dvfs_pstate_seq dvfs_pstate_seq_chk #(.VW(VW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .freq_code(freq_code), .volt_code(volt_code),
  .vr_cmd(vr_cmd), .pll_relock(pll_relock), .busy(busy)
);

// File: tb/tb_dvfs_pstate_seq.sv
module tb_dvfs_pstate_seq;
  localparam int NCORE = 4, NPS = 8, PSW = 3, VW = 8, FW = 8;
  localparam int STEP_GAP = 4;

  logic clk = 0, rst = 1;
  logic [NCORE*PSW-1:0] core_req = '0;
  logic [NCORE-1:0] core_active = '0;
  logic pll_locked = 1, vr_ack = 0;
  logic [FW-1:0] freq_code;
  logic [VW-1:0] volt_code;
  logic vr_cmd, pll_relock, busy;

  dvfs_pstate_seq dut (
    .clk(clk), .rst(rst), .core_req(core_req), .core_active(core_active),
    .pll_locked(pll_locked), .vr_ack(vr_ack), .freq_code(freq_code),
    .volt_code(volt_code), .vr_cmd(vr_cmd), .pll_relock(pll_relock), .busy(busy)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cur_ps = NPS - 1, cur_cnt = 1;
  int cmd_pre = 0, cmd_post = 0, strobes = 0, busy_cyc = 0;
  int step_bad = 0, gap_bad = 0, ack_bad = 0, lock_bad = 0, cycles = 0;
  int since_cmd = 1000, ack_seen = 1, ack_dly = 0, lk_dly = 0;
  logic [VW-1:0] prev_v;
  logic prev_busy = 0;

  function automatic int vexp(int p, int n);
    return 40 + (NPS - 1 - p) * 3 + (n - 1);
  endfunction
  function automatic int fexp(int p);
    return 8 + (NPS - 1 - p) * 4;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor and external models, all at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
    if (!rst) begin
      since_cmd++;
      if (busy) busy_cyc++;
      if (vr_cmd) begin
        if (!((volt_code == prev_v + 8'd1) || (volt_code == prev_v - 8'd1))) step_bad++;
        if (since_cmd < STEP_GAP) gap_bad++;
        if (!ack_seen) ack_bad++;
        since_cmd = 0;
        ack_seen = 0;
        if (strobes == 0) cmd_pre++; else cmd_post++;
      end
      if (pll_relock) strobes++;
      if (prev_busy && !busy && !pll_locked) lock_bad++;
    end
    prev_v = volt_code;
    prev_busy = busy;
    // regulator model
    vr_ack = 0;
    if (ack_dly > 0) begin
      ack_dly--;
      if (ack_dly == 0) begin vr_ack = 1; ack_seen = 1; end
    end
    if (vr_cmd) ack_dly = 2;
    // clock generator model
    if (pll_relock) begin pll_locked = 0; lk_dly = 5; end
    else if (lk_dly > 0) begin
      lk_dly--;
      if (lk_dly == 0) pll_locked = 1;
    end
  end

  task automatic drive(input int tps, input int tcnt, input int w);
    logic [NCORE-1:0] m;
    m = '0;
    for (int k = 0; k < tcnt; k++) m[(w + k) % NCORE] = 1'b1;
    for (int i = 0; i < NCORE; i++) begin
      int r;
      if (!m[i]) r = 0;
      else if (i == w) r = tps;
      else r = (tps + 1 + i < NPS) ? tps + 1 + i : NPS - 1;
      core_req[i*PSW +: PSW] = PSW'(r);
    end
    core_active = m;
  endtask

  task automatic wait_busy(input logic lvl, input int lim, output bit ok);
    int n = 0;
    while (busy !== lvl && n < lim) begin @(negedge clk); n++; end
    ok = (busy === lvl);
  endtask

  task automatic move(input int tps, input int tcnt, input int w);
    bit ok, chg;
    int dv;
    @(negedge clk);
    cmd_pre = 0; cmd_post = 0; strobes = 0; busy_cyc = 0;
    chg = (tps != cur_ps) || (tcnt != cur_cnt);
    dv = vexp(tps, tcnt) - vexp(cur_ps, cur_cnt);
    if (dv < 0) dv = -dv;
    drive(tps, tcnt, w);
    if (chg) begin
      wait_busy(1'b1, 10, ok);
      check(ok, "R13 busy rise", busy, 1);
      wait_busy(1'b0, 5000, ok);
      check(ok, "R13 busy fall", busy, 0);
      if (tps < cur_ps) check(cmd_post == 0 && cmd_pre == dv, "R5 order", cmd_post, 0);
      else if (tps > cur_ps) check(cmd_pre == 0 && cmd_post == dv && strobes == 1, "R6 order", cmd_pre, 0);
      else check(strobes == 0 && cmd_pre == dv, "R6 supply only", strobes, 0);
    end else begin
      repeat (8) @(negedge clk);
      check(busy_cyc == 0, "R12 no move", busy_cyc, 0);
    end
    check(freq_code == fexp(tps), "R2 R4 freq", freq_code, fexp(tps));
    check(volt_code == vexp(tps, tcnt), "R3 volt", volt_code, vexp(tps, tcnt));
    cur_ps = tps; cur_cnt = tcnt;
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(freq_code == fexp(NPS - 1), "R1 freq", freq_code, fexp(NPS - 1));
    check(volt_code == vexp(NPS - 1, 1), "R1 volt", volt_code, vexp(NPS - 1, 1));
    check(!busy && !vr_cmd && !pll_relock, "R1 idle", busy, 0);

    // R11: nobody active, requests of index 0 must not act
    core_req = '0; core_active = '0; busy_cyc = 0;
    repeat (10) @(negedge clk);
    check(busy_cyc == 0 && freq_code == fexp(NPS - 1), "R11 none active", busy_cyc, 0);

    // R12: same point requested again
    move(NPS - 1, 1, 2);

    // full sweep of ordered index pairs, R2 R3 R4 R5 R6
    for (int a = 0; a < NPS; a++)
      for (int b = 0; b < NPS; b++) begin
        move(a, ((a + b) % NCORE) + 1, (a * 3 + b) % NCORE);
        move(b, ((a * b) % NCORE) + 1, (a + 2 * b) % NCORE);
      end

    // R10: change request in the middle of the widest upward ramp
    move(NPS - 1, 1, 0);
    @(negedge clk);
    drive(0, NCORE, 1);
    wait_busy(1'b1, 10, ok);
    repeat (20) @(negedge clk);
    drive(3, 2, 3);
    wait_busy(1'b0, 5000, ok);
    check(freq_code == fexp(0), "R10 first freq", freq_code, fexp(0));
    check(volt_code == vexp(0, NCORE), "R10 first volt", volt_code, vexp(0, NCORE));
    wait_busy(1'b1, 10, ok);
    check(ok, "R10 held start", busy, 1);
    wait_busy(1'b0, 5000, ok);
    check(freq_code == fexp(3) && volt_code == vexp(3, 2), "R10 held target", volt_code, vexp(3, 2));
    cur_ps = 3; cur_cnt = 2;

    // R11 again after moves: mask cleared, codes frozen
    @(negedge clk);
    core_active = '0; core_req = '0; busy_cyc = 0;
    repeat (12) @(negedge clk);
    check(busy_cyc == 0 && volt_code == vexp(3, 2), "R11 frozen", volt_code, vexp(3, 2));

    check(step_bad == 0, "R7 unit steps", step_bad, 0);
    check(gap_bad == 0 && ack_bad == 0, "R8 pacing", gap_bad + ack_bad, 0);
    check(lock_bad == 0, "R9 lock wait", lock_bad, 0);
    finish_run();
  end

endmodule